// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches a small number of recent page translations and turns a 31-bit virtual address into a 27-bit physical address in the same cycle as the request. Pages are 4 KB, so the low 12 bits are the page offset and pass through unchanged. The upper 19 bits form the virtual page number. The block compares that number against every stored entry in parallel. On a match, the block builds the physical address from the entry's 15-bit physical page number followed by the offset. When the strobe is high and no entry matches, the block raises a miss flag and does nothing else. Walking the page table and refilling the buffer are the job of surrounding logic.

Refills arrive on a fill port that carries a page-number pair. A new virtual page number goes into the slot named by a round-robin pointer. A virtual page number that is already stored has its existing slot rewritten. A flush input invalidates the whole buffer in one cycle. The entry count is a parameter with a default of 2 and a maximum of 16. A second parameter selects either combinational results or results registered at the clock edge.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and the round-robin pointer starts at slot 0.
- R2: On a hit, physical address bits [11:0] equal virtual address bits [11:0] for every offset value.
- R3: A lookup hits when a valid entry's stored page number equals virtual address bits [30:12]. Physical address bits [26:12] then equal that entry's physical page number. With page 0x00002 mapped to 0x7FFF, address 0x247C gives 0x7FFF47C. With 0x7FFFD mapped to 0x0000, address 0x7FFFDABC gives 0x0000ABC.
- R4: With the strobe high and no matching entry, the miss flag is 1, the hit flag is 0 and the physical address is 0. With the strobe low, both flags are 0 and the physical address is 0.
- R5: A fill with a page number not present in any valid entry writes the slot named by the pointer, marks it valid and advances the pointer, which wraps from ENTRIES-1 to 0. With 2 entries, the third distinct fill evicts the first.
- R6: A fill whose page number already sits in a valid entry rewrites that entry's physical page number in place and leaves the pointer unchanged. No two valid entries ever hold the same page number. If two ever did, the lower index would win.
- R7: A flush invalidates every entry in one cycle and returns the pointer to slot 0. A fill in the same cycle as a flush is discarded.
- R8: A fill takes effect from the next clock edge. A lookup in the same cycle as a fill sees the contents from before the fill.
- R9: With REG_OUT=1, hit, miss and physical address appear one clock after the strobe, computed from the inputs and contents present at that edge. With REG_OUT=0 they are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | VA_W (31) | Virtual address to translate |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VA_W-OFF_W (19) | Virtual page number to install |
| fill_ppn | input | PA_W-OFF_W (15) | Physical page number to install |
| flush | input | 1 | Invalidate all entries |
| hit_o | output | 1 | Lookup matched a valid entry |
| miss_o | output | 1 | Lookup strobed without a match |
| pa_o | output | PA_W (27) | Translated physical address |

## Verification
Two pairs of actions can fall in the same cycle: a lookup with a fill, and a fill with a flush. The bench raises both the fill and lookup strobes at one falling edge for the same page. It expects a miss before the edge, and in the registered instance as well. It then expects a hit on the following lookup. It also drives a flush together with a fill of a fresh page. The fill counts as discarded if a later lookup of that page misses and a later sequence of three fills evicts slot 0 first, which shows the pointer returned to zero. A pseudo-random mix of fills, flushes and lookups over a few page numbers is scored against a reference model kept in the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int unsigned TLB_VA_W        = 31;
   localparam int unsigned TLB_PA_W        = 27;
   localparam int unsigned TLB_OFF_W       = 12;
   localparam int unsigned TLB_MAX_ENTRIES = 16;
endpackage

// File: rtl/tlb_fill_ptr.sv
module tlb_fill_ptr #(
   parameter int unsigned ENTRIES = 2,
   parameter int unsigned IDX_W   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         ptr <= '0;
      else if (advance)
         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   // R5
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
   parameter int unsigned ENTRIES = 2,
   parameter int unsigned VPN_W   = 19,
   parameter int unsigned PPN_W   = 15,
   parameter int unsigned IDX_W   = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [VPN_W-1:0]              wr_vpn,
   input  logic [PPN_W-1:0]              wr_ppn,
   output logic [ENTRIES-1:0]            valid_q,
   output logic [ENTRIES-1:0][VPN_W-1:0] vpn_q,
   output logic [ENTRIES-1:0][PPN_W-1:0] ppn_q
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
            vpn_q[e]   <= '0;
            ppn_q[e]   <= '0;
         end else if (flush) begin
            valid_q[e] <= 1'b0;
         end else if (sel) begin
            valid_q[e] <= 1'b1;
            vpn_q[e]   <= wr_vpn;
            ppn_q[e]   <= wr_ppn;
         end
      end
   end

   // R7
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !wr_en) |=> $stable(valid_q));

   // R5
   fill_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
   parameter int unsigned ENTRIES = 2,
   parameter int unsigned VPN_W   = 19,
   parameter int unsigned PPN_W   = 15,
   parameter int unsigned IDX_W   = 1
) (
   input  logic [ENTRIES-1:0]            valid,
   input  logic [ENTRIES-1:0][VPN_W-1:0] vpn,
   input  logic [ENTRIES-1:0][PPN_W-1:0] ppn,
   input  logic [VPN_W-1:0]              key,
   output logic [ENTRIES-1:0]            match_vec,
   output logic                          any_hit,
   output logic [IDX_W-1:0]              hit_idx,
   output logic [PPN_W-1:0]              hit_ppn
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match_vec[e] = valid[e] && (vpn[e] == key);
   end

   assign any_hit = |match_vec;

   // scan from the top down so the lowest matching index is kept
   always_comb begin
      hit_idx = '0;
      hit_ppn = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (match_vec[e]) begin
            hit_idx = IDX_W'(e);
            hit_ppn = ppn[e];
         end
      end
   end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int unsigned ENTRIES = 2,
   parameter int unsigned VA_W    = TLB_VA_W,
   parameter int unsigned PA_W    = TLB_PA_W,
   parameter int unsigned OFF_W   = TLB_OFF_W,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lk_valid,
   input  logic [VA_W-1:0]        lk_vaddr,
   input  logic                   fill_en,
   input  logic [VA_W-OFF_W-1:0]  fill_vpn,
   input  logic [PA_W-OFF_W-1:0]  fill_ppn,
   input  logic                   flush,
   output logic                   hit_o,
   output logic                   miss_o,
   output logic [PA_W-1:0]        pa_o
);
   localparam int unsigned VPN_W = VA_W - OFF_W;
   localparam int unsigned PPN_W = PA_W - OFF_W;
   localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 1 || ENTRIES > TLB_MAX_ENTRIES) begin : g_bad_entries
      $error("tlb_xlate: ENTRIES out of range 1..16");
   end
   if (OFF_W >= VA_W || OFF_W >= PA_W) begin : g_bad_widths
      $error("tlb_xlate: page offset must be narrower than both addresses");
   end

   logic [ENTRIES-1:0]            valid_q;
   logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
   logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
   logic [IDX_W-1:0]              ptr;

   logic [ENTRIES-1:0] lk_match, fl_match;
   logic               lk_any, fl_any;
   logic [IDX_W-1:0]   lk_idx, fl_idx;
   logic [PPN_W-1:0]   lk_ppn, fl_ppn_unused;

   logic             fill_go;
   logic [IDX_W-1:0] wr_idx;

   tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_lk_match (
      .valid(valid_q), .vpn(vpn_q), .ppn(ppn_q), .key(lk_vaddr[VA_W-1:OFF_W]),
      .match_vec(lk_match), .any_hit(lk_any), .hit_idx(lk_idx), .hit_ppn(lk_ppn));

   tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_fill_match (
      .valid(valid_q), .vpn(vpn_q), .ppn(ppn_q), .key(fill_vpn),
      .match_vec(fl_match), .any_hit(fl_any), .hit_idx(fl_idx), .hit_ppn(fl_ppn_unused));

   assign fill_go = fill_en && !flush;
   assign wr_idx  = fl_any ? fl_idx : ptr;

   tlb_fill_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .clear(flush),
      .advance(fill_go && !fl_any), .ptr(ptr));

   tlb_entry_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(fill_go), .wr_idx(wr_idx),
      .wr_vpn(fill_vpn), .wr_ppn(fill_ppn),
      .valid_q(valid_q), .vpn_q(vpn_q), .ppn_q(ppn_q));

   logic            hit_c, miss_c;
   logic [PA_W-1:0] pa_c;

   assign hit_c  = lk_valid && lk_any;
   assign miss_c = lk_valid && !lk_any;
   assign pa_c   = hit_c ? {lk_ppn, lk_vaddr[OFF_W-1:0]} : '0;

   if (REG_OUT) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hit_o  <= 1'b0;
            miss_o <= 1'b0;
            pa_o   <= '0;
         end else begin
            hit_o  <= hit_c;
            miss_o <= miss_c;
            pa_o   <= pa_c;
         end
      end

      // R2
      offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hit_c |=> (pa_o[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));
   end else begin : g_out_comb
      assign hit_o  = hit_c;
      assign miss_o = miss_c;
      assign pa_o   = pa_c;

      // R2
      offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hit_o |-> (pa_o[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
   end

   // R6
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));

   // R4
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_o && miss_o));
endmodule

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
module tlb_xlate_test;
   localparam int N = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_valid;
   logic [30:0] lk_vaddr;
   logic        fill_en;
   logic [18:0] fill_vpn;
   logic [14:0] fill_ppn;
   logic        flush;
   logic        hit_c, miss_c, hit_r, miss_r;
   logic [26:0] pa_c, pa_r;

   int checks = 0;
   int fails  = 0;

   logic        m_v   [N];
   logic [18:0] m_vpn [N];
   logic [14:0] m_ppn [N];
   int          m_ptr;

   always #4 clk = ~clk;

   tlb_xlate #(.ENTRIES(N), .REG_OUT(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush(flush),
      .hit_o(hit_c), .miss_o(miss_c), .pa_o(pa_c));

   tlb_xlate #(.ENTRIES(N), .REG_OUT(1'b1)) uut_reg (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush(flush),
      .hit_o(hit_r), .miss_o(miss_r), .pa_o(pa_r));

   task automatic check(input string req, input logic [28:0] act, input logic [28:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [28:0] calc(input logic [30:0] va);
      logic [28:0] r;
      r = {1'b0, 1'b1, 27'd0};
      for (int i = N - 1; i >= 0; i--)
         if (m_v[i] && m_vpn[i] == va[30:12]) r = {1'b1, 1'b0, m_ppn[i], va[11:0]};
      return r;
   endfunction

   task automatic m_fill(input logic [18:0] vpn, input logic [14:0] ppn);
      int slot;
      slot = -1;
      for (int i = N - 1; i >= 0; i--)
         if (m_v[i] && m_vpn[i] == vpn) slot = i;
      if (slot >= 0) m_ppn[slot] = ppn;
      else begin
         m_v[m_ptr] = 1'b1; m_vpn[m_ptr] = vpn; m_ppn[m_ptr] = ppn;
         m_ptr = (m_ptr + 1) % N;
      end
   endtask

   task automatic m_flush();
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      m_ptr = 0;
   endtask

   task automatic look(input logic [30:0] va, input string req);
      logic [28:0] e;
      @(negedge clk);
      fill_en = 1'b0; flush = 1'b0; lk_valid = 1'b1; lk_vaddr = va;
      #1;
      e = calc(va);
      check(req, {hit_c, miss_c, pa_c}, e);
      @(posedge clk); #1;
      check({req, " R9"}, {hit_r, miss_r, pa_r}, e);
   endtask

   task automatic do_fill(input logic [18:0] vpn, input logic [14:0] ppn);
      @(negedge clk);
      lk_valid = 1'b0; flush = 1'b0;
      fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
      @(posedge clk); #1;
      m_fill(vpn, ppn);
      fill_en = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      lk_valid = 1'b0; fill_en = 1'b0; flush = 1'b1;
      @(posedge clk); #1;
      m_flush();
      flush = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      logic [28:0] e;
      rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0;
      fill_en = 1'b0; fill_vpn = '0; fill_ppn = '0; flush = 1'b0;
      m_flush();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: empty after reset
      look(31'h247C, "R1");
      look(31'h0, "R1");
      look(31'h7FFFDABC, "R1");

      // R3: worked translations
      do_fill(19'h00002, 15'h7FFF);
      do_fill(19'h7FFFD, 15'h0000);
      look(31'h247C, "R3");
      check("R3 example", {hit_c, miss_c, pa_c}, {1'b1, 1'b0, 27'h7FFF47C});
      look(31'h7FFFDABC, "R3");
      check("R3 example", {hit_c, miss_c, pa_c}, {1'b1, 1'b0, 27'h0000ABC});

      // R2: every page offset on a hitting page
      for (int o = 0; o < 4096; o++) look({19'h00002, o[11:0]}, "R2");

      // R4: unmatched and unstrobed
      look(31'h00003000, "R4");
      @(negedge clk);
      lk_valid = 1'b0; lk_vaddr = 31'h247C; #1;
      check("R4 idle", {hit_c, miss_c, pa_c}, 29'd0);
      @(posedge clk); #1;
      check("R4 idle R9", {hit_r, miss_r, pa_r}, 29'd0);

      // R5: third distinct fill evicts slot 0
      do_fill(19'h12345, 15'h1111);
      look(31'h0000247C, "R5");
      look({19'h12345, 12'h0FF}, "R5");
      look({19'h7FFFD, 12'h001}, "R5");

      // R6: refill of a resident page, pointer must stay on slot 1
      do_fill(19'h7FFFD, 15'h2222);
      look({19'h7FFFD, 12'h123}, "R6");
      do_fill(19'h00040, 15'h0003);
      look({19'h12345, 12'h456}, "R6");
      look({19'h00040, 12'h789}, "R6");
      look({19'h7FFFD, 12'h123}, "R6");

      // R8: fill and lookup of the same page in one cycle
      @(negedge clk);
      flush = 1'b0; fill_en = 1'b1; fill_vpn = 19'h55555; fill_ppn = 15'h4444;
      lk_valid = 1'b1; lk_vaddr = {19'h55555, 12'h010};
      #1;
      e = calc(lk_vaddr);
      check("R8 same cycle", {hit_c, miss_c, pa_c}, e);
      @(posedge clk); #1;
      check("R8 same cycle R9", {hit_r, miss_r, pa_r}, e);
      m_fill(19'h55555, 15'h4444);
      fill_en = 1'b0;
      look({19'h55555, 12'h010}, "R8");

      // R7: flush beats a simultaneous fill, pointer back to 0
      @(negedge clk);
      lk_valid = 1'b0; flush = 1'b1; fill_en = 1'b1;
      fill_vpn = 19'h00777; fill_ppn = 15'h0777;
      @(posedge clk); #1;
      m_flush();
      flush = 1'b0; fill_en = 1'b0;
      look({19'h00777, 12'h0}, "R7");
      look({19'h55555, 12'h010}, "R7");
      do_fill(19'h00A00, 15'h0A00);
      do_fill(19'h00B00, 15'h0B00);
      do_fill(19'h00C00, 15'h0C00);
      look({19'h00A00, 12'h0}, "R7");
      look({19'h00B00, 12'h0}, "R7");
      look({19'h00C00, 12'h0}, "R7");

      // R5 R6 R7: mixed traffic over a few pages
      lf = 16'hACE1;
      for (int k = 0; k < 600; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         case (lf[1:0])
            2'd0, 2'd1: do_fill({16'd0, lf[6:4]}, lf[15:1]);
            2'd2:       look({16'd0, lf[6:4], lf[13:2]}, "R5 R6 mix");
            default:    if (lf[9:7] == 3'd0) do_flush();
                        else look({16'd0, lf[5:3], lf[14:3]}, "R7 mix");
         endcase
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule